// File: doc/BRIEF.md
# Low-speed USB packet receiver

This block takes the two data lines of a low-speed USB link and turns each incoming packet into a sequence of byte writes into a receive buffer. It runs from a system clock at ten times the bit rate. The lines pass through a two-flop synchroniser. A phase counter restarts on every line transition, so the sampling point stays near the centre of each bit while following the sender's timing.

A packet begins with a J-to-K edge on an idle (J) bus. The receiver then hunts for the end of the sync field, which is the first time two consecutive bit samples are both K. After that it decodes NRZI, drops stuffed bits and assembles bytes least significant bit first. Each finished byte is presented with a one-cycle write strobe, a byte address and the data.

An SE0 ends the packet, except in the first bit slot of a byte, where a hub may add a dribble bit. At the end of a packet the block pulses a done flag together with the byte count. A single error pulse reports either a full byte budget or a failed sync search. CRC, PID and endpoint handling belong to the logic behind the buffer.

Top module: `lsusb_rx`

## Requirements
- R1: After reset, bufWrEn, pktDone and rxErr are low, and they stay low while the bus idles in J ({dp,dm} = 01).
- R2: Reception starts only on a J-to-K edge. K is {dp,dm} = 10. Any number of K/J pairs may come before the final two K bits. Data bit 0 is the bit that follows the second consecutive K sample.
- R3: Data is NRZI-decoded: an unchanged level gives 1 and a changed level gives 0. Bytes are assembled LSB first. Each byte produces a one-cycle bufWrEn with bufWrAddr equal to its 0-based index in the packet.
- R4: After six consecutive decoded 1 bits, the next bit is discarded and does not enter the byte. The final sync bit counts as the first 1 of that run.
- R5: An SE0 ({dp,dm} = 00) sampled in any bit slot other than slot 0 of a byte ends the packet. pktDone then pulses for one cycle, pktLen equals the number of bytes written, and a partial byte is dropped.
- R6: An SE0 sampled in slot 0 of a byte does not end the packet. It fills that slot as a 0 data bit and leaves the level history and the 1-run count untouched.
- R7: When a byte completes while BUF_DEPTH bytes are already stored, that byte is not written. rxErr pulses and no pktDone follows. The receiver then ignores the bus until it sees an SE0 followed by J. A packet of exactly BUF_DEPTH bytes completes normally.
- R8: During the sync search, if the line is not K for SYNC_LIMIT cycles since its last transition, rxErr pulses, nothing is written and the receiver returns to idle.
- R9: The phase counter restarts on every transition, so packets whose bit lengths alternate between 9 and 11 clocks decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, ten times the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| usbDp | input | 1 | D+ line, asynchronous |
| usbDm | input | 1 | D- line, asynchronous |
| bufWrEn | output | 1 | One-cycle write strobe for a received byte |
| bufWrAddr | output | ADDR_W | Byte index within the packet |
| bufWrData | output | 8 | Received byte |
| pktDone | output | 1 | One-cycle pulse at the end of a good packet |
| pktLen | output | CNT_W | Byte count, valid with pktDone |
| rxErr | output | 1 | One-cycle pulse on buffer overflow or sync timeout |

## Verification
The completion of a byte and the byte-budget test are decided on the same bit sample. On that sample the block must either store the byte or raise the overflow error, and never both. The bench provokes this with a packet of exactly BUF_DEPTH bytes, which must end with pktDone and no error. It follows that with a packet one byte longer, which must produce BUF_DEPTH writes, a single rxErr and no pktDone, and then a short packet to show the receiver re-arms. The first SE0 of every end-of-packet marker also lands on the slot right after the final byte is stored, so the dribble rule and the last write are exercised back to back in every table vector.

// File: rtl/lsusb_rx_pkg.sv
package lsusb_rx_pkg;

  // Line symbol as {dp, dm}
  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } lineSym_e;

  // Decoded 1 bits after which a stuffed bit follows
  localparam int STUFF_RUN = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_RECV,
    ST_DRAIN_SE0,
    ST_DRAIN_J
  } rxState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic beginRx;
    logic takeBit;
    logic endPkt;
    logic flagErr;
  } rxCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic sampleTick;
    logic jkEdge;
    logic timedOut;
    logic slotZero;
    logic byteWillComplete;
    logic bufFull;
  } rxStat_t;

endpackage

// File: rtl/lsusb_rx_sync.sv
module lsusb_rx_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/lsusb_rx_dpath.sv
module lsusb_rx_dpath
  import lsusb_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int BUF_DEPTH = 8,
  parameter int SYNC_LIMIT = 15,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W = 3,
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dpIn,
  input  logic              dmIn,
  input  rxCtl_t            ctl,
  output rxStat_t           stat,
  output lineSym_e          symNow,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic              pktDone,
  output logic [CNT_W-1:0]  pktLen,
  output logic              rxErr
);
  localparam int PH_W = $clog2(CLKS_PER_BIT);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLKS_PER_BIT - 1);
  localparam logic [PH_W-1:0] SAMPLE_AT = PH_W'(CLKS_PER_BIT / 2 - 1);
  localparam int STILL_W = $clog2(SYNC_LIMIT + 1);
  localparam logic [STILL_W-1:0] STILL_MAX = STILL_W'(SYNC_LIMIT);

  logic [1:0] lineS;
  lineSym_e symPrev;
  logic edgeSeen;
  logic [PH_W-1:0] phase;
  logic [STILL_W-1:0] stillCnt;

  lsusb_rx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b01)) sync_i (
    .clk(clk), .rstN(rstN), .d({dpIn, dmIn}), .q(lineS)
  );

  assign symNow = lineSym_e'(lineS);
  assign edgeSeen = (symNow != symPrev);

  // Bit timing: phase restarts on every transition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      symPrev  <= SYM_J;
      phase    <= '0;
      stillCnt <= '0;
    end else begin
      symPrev <= symNow;
      if (edgeSeen || phase == PH_LAST) phase <= '0;
      else                              phase <= phase + 1'b1;
      if (edgeSeen)                   stillCnt <= '0;
      else if (stillCnt != STILL_MAX) stillCnt <= stillCnt + 1'b1;
    end
  end

  // Decode state
  logic lvl, prevLvl, rawBit, isStuff, isSe0;
  logic [2:0] onesRun;
  logic [2:0] bitIdx;
  logic [7:0] shiftReg;
  logic [CNT_W-1:0] byteCnt;

  assign lvl     = lineS[0];
  assign rawBit  = (lvl == prevLvl);
  assign isStuff = (onesRun == 3'(STUFF_RUN));
  assign isSe0   = (symNow == SYM_SE0);

  always_comb begin
    stat.sampleTick       = !edgeSeen && (phase == SAMPLE_AT);
    stat.jkEdge           = (symPrev == SYM_J) && (symNow == SYM_K);
    stat.timedOut         = (stillCnt == STILL_MAX);
    stat.slotZero         = (bitIdx == 3'd0);
    stat.byteWillComplete = !isSe0 && !isStuff && (bitIdx == 3'd7);
    stat.bufFull          = (byteCnt == CNT_W'(BUF_DEPTH));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl   <= 1'b0;
      onesRun   <= '0;
      bitIdx    <= '0;
      shiftReg  <= '0;
      byteCnt   <= '0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
      pktDone   <= 1'b0;
      pktLen    <= '0;
      rxErr     <= 1'b0;
    end else begin
      bufWrEn <= 1'b0;
      pktDone <= 1'b0;
      rxErr   <= ctl.flagErr;
      if (ctl.beginRx) begin
        prevLvl <= 1'b0;
        onesRun <= 3'd1;
        bitIdx  <= '0;
        byteCnt <= '0;
      end
      if (ctl.takeBit) begin
        if (isSe0) begin
          // dribble slot: fills the slot, history untouched
          shiftReg <= {1'b0, shiftReg[7:1]};
          bitIdx   <= bitIdx + 1'b1;
        end else begin
          prevLvl <= lvl;
          if (isStuff) begin
            onesRun <= '0;
          end else begin
            onesRun  <= rawBit ? onesRun + 1'b1 : 3'd0;
            shiftReg <= {rawBit, shiftReg[7:1]};
            bitIdx   <= bitIdx + 1'b1;
            if (bitIdx == 3'd7) begin
              bufWrEn   <= 1'b1;
              bufWrData <= {rawBit, shiftReg[7:1]};
              bufWrAddr <= byteCnt[ADDR_W-1:0];
              byteCnt   <= byteCnt + 1'b1;
            end
          end
        end
      end
      if (ctl.endPkt) begin
        pktDone <= 1'b1;
        pktLen  <= byteCnt;
      end
    end
  end
endmodule

// File: rtl/lsusb_rx_ctrl.sv
module lsusb_rx_ctrl
  import lsusb_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  rxStat_t  stat,
  input  lineSym_e symNow,
  output rxCtl_t   ctl
);
  rxState_e state, stateNxt;
  logic lastK, lastKNxt;

  always_comb begin
    stateNxt = state;
    lastKNxt = lastK;
    ctl      = '0;
    case (state)
      ST_IDLE: begin
        if (stat.jkEdge) begin
          stateNxt = ST_SYNC;
          lastKNxt = 1'b0;
        end
      end
      ST_SYNC: begin
        if (stat.timedOut && symNow != SYM_K) begin
          ctl.flagErr = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (stat.sampleTick) begin
          if (symNow == SYM_K) begin
            if (lastK) begin
              ctl.beginRx = 1'b1;
              stateNxt    = ST_RECV;
            end
            lastKNxt = 1'b1;
          end else begin
            lastKNxt = 1'b0;
          end
        end
      end
      ST_RECV: begin
        if (stat.sampleTick) begin
          if (symNow == SYM_SE0 && !stat.slotZero) begin
            ctl.endPkt = 1'b1;
            stateNxt   = ST_IDLE;
          end else if (stat.byteWillComplete && stat.bufFull) begin
            ctl.flagErr = 1'b1;
            stateNxt    = ST_DRAIN_SE0;
          end else begin
            ctl.takeBit = 1'b1;
          end
        end
      end
      ST_DRAIN_SE0: if (symNow == SYM_SE0) stateNxt = ST_DRAIN_J;
      ST_DRAIN_J:   if (symNow == SYM_J)   stateNxt = ST_IDLE;
      default:      stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      lastK <= 1'b0;
    end else begin
      state <= stateNxt;
      lastK <= lastKNxt;
    end
  end
endmodule

// File: rtl/lsusb_rx.sv
module lsusb_rx
  import lsusb_rx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int BUF_DEPTH = 8,
  parameter int SYNC_LIMIT = 15,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usbDp,
  input  logic              usbDm,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic              pktDone,
  output logic [CNT_W-1:0]  pktLen,
  output logic              rxErr
);
  rxCtl_t   ctl;
  rxStat_t  stat;
  lineSym_e symNow;

  lsusb_rx_dpath #(
    .CLKS_PER_BIT(CLKS_PER_BIT), .BUF_DEPTH(BUF_DEPTH), .SYNC_LIMIT(SYNC_LIMIT),
    .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .dpIn(usbDp), .dmIn(usbDm), .ctl(ctl), .stat(stat),
    .symNow(symNow), .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .pktDone(pktDone), .pktLen(pktLen), .rxErr(rxErr)
  );

  lsusb_rx_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .stat(stat), .symNow(symNow), .ctl(ctl)
  );
endmodule

// File: rtl/lsusb_rx_chk.sv
module lsusb_rx_chk #(
  parameter int BUF_DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             bufWrEn,
  input logic             pktDone,
  input logic [CNT_W-1:0] pktLen,
  input logic             rxErr
);
  // R3: bytes are at least one bit apart, so strobes never repeat back to back
  a_r3_write_spacing: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |=> !bufWrEn);

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);

  // R5: reported length never exceeds the budget
  a_r5_len_bound: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> (pktLen <= CNT_W'(BUF_DEPTH)));

  // R7: write, done and error never share a cycle
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({bufWrEn, pktDone, rxErr}));

  // R8: error is a single-cycle pulse
  a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |=> !rxErr);
endmodule

bind lsusb_rx lsusb_rx_chk #(.BUF_DEPTH(BUF_DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .bufWrEn(bufWrEn), .pktDone(pktDone),
  .pktLen(pktLen), .rxErr(rxErr)
);

// File: tb/lsusb_rx_tb_top.sv
`timescale 1ns/1ps
module lsusb_rx_tb_top;
  localparam int DEPTH = 8;
  localparam int WD_CYCLES = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usbDp = 1'b0;
  logic usbDm = 1'b1;
  logic bufWrEn;
  logic [2:0] bufWrAddr;
  logic [7:0] bufWrData;
  logic pktDone;
  logic [3:0] pktLen;
  logic rxErr;

  always #4 clk = ~clk;

  lsusb_rx #(.BUF_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN), .usbDp(usbDp), .usbDm(usbDm), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .pktDone(pktDone),
    .pktLen(pktLen), .rxErr(rxErr)
  );

  int tests = 0;
  int failed = 0;
  bit finished = 0;

  // Output monitor, sampled away from the active edge
  logic [7:0] wrLog [0:127];
  int wrAddrLog [0:127];
  int wrCnt = 0, doneCnt = 0, errCnt = 0, lastLen = -1;

  always @(negedge clk) begin
    if (rstN) begin
      if (bufWrEn) begin
        if (wrCnt < 128) begin
          wrLog[wrCnt] = bufWrData;
          wrAddrLog[wrCnt] = int'(bufWrAddr);
        end
        wrCnt++;
      end
      if (pktDone) begin
        doneCnt++;
        lastLen = int'(pktLen);
      end
      if (rxErr) errCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Line encoder
  bit jitMode = 0;
  bit jitTog = 0;
  logic encLvl = 1'b0;
  int encRun = 0;

  task automatic holdBit(input logic dp, input logic dm);
    int d;
    d = 10;
    if (jitMode) begin
      d = jitTog ? 9 : 11;
      jitTog = !jitTog;
    end
    usbDp = dp;
    usbDm = dm;
    repeat (d) @(negedge clk);
  endtask

  task automatic lvlBit(input logic l);   // l = 1 is J
    holdBit(!l, l);
  endtask

  task automatic se0Bit();
    holdBit(1'b0, 1'b0);
  endtask

  task automatic dataBit(input logic b);
    if (!b) encLvl = !encLvl;
    lvlBit(encLvl);
    if (b) begin
      encRun++;
      if (encRun == 6) begin
        encLvl = !encLvl;
        lvlBit(encLvl);
        encRun = 0;
      end
    end else begin
      encRun = 0;
    end
  endtask

  task automatic sendIdle(input int nBits);
    for (int i = 0; i < nBits; i++) lvlBit(1'b1);
  endtask

  task automatic sendSync(input int pairs);
    for (int i = 0; i < pairs; i++) begin
      lvlBit(1'b0);
      lvlBit(1'b1);
    end
    lvlBit(1'b0);
    lvlBit(1'b0);
    encLvl = 1'b0;
    encRun = 1;
  endtask

  task automatic sendByte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) dataBit(b[i]);
  endtask

  task automatic sendEop();
    se0Bit();
    se0Bit();
    sendIdle(3);
  endtask

  // Table of packets: length, jitter flag, bytes (byte i at bits 8i+7:8i)
  typedef struct packed {
    logic [3:0]  n;
    logic        jit;
    logic [63:0] data;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b0, 64'h0000_0000_0000_00A5},  // R3 plain byte
    '{4'd2, 1'b0, 64'h0000_0000_0000_FFFF},  // R4 stuffing across bytes
    '{4'd3, 1'b0, 64'h0000_0000_007E_8000},  // R3 mixed levels
    '{4'd4, 1'b1, 64'h0000_0000_01FE_3CC3},  // R9 jittered bit lengths
    '{4'd8, 1'b0, 64'h0123_4567_89AB_CDEF}   // R7 exactly full budget
  };

  int bw, bd, be;

  task automatic snap();
    bw = wrCnt;
    bd = doneCnt;
    be = errCnt;
  endtask

  task automatic quickPkt(input logic [7:0] b, input string tag);
    snap();
    sendIdle(3);
    sendSync(3);
    sendByte(b);
    sendEop();
    check(doneCnt - bd == 1, {tag, " recovery done"}, doneCnt - bd, 1);
    check(wrCnt - bw == 1 && wrLog[bw] == b, {tag, " recovery byte"}, int'(wrLog[bw]), int'(b));
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state and quiet idle
    check(bufWrEn == 1'b0, "R1 bufWrEn after reset", int'(bufWrEn), 0);
    check(pktDone == 1'b0 && rxErr == 1'b0, "R1 done/err after reset",
          int'({pktDone, rxErr}), 0);
    sendIdle(6);
    check(wrCnt + doneCnt + errCnt == 0, "R1 idle produces no events",
          wrCnt + doneCnt + errCnt, 0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = (v == 1) ? "R4" : (v == 3) ? "R9" : (v == 4) ? "R7" : "R3";
      snap();
      jitMode = VECS[v].jit;
      jitTog = 0;
      sendIdle(3);
      sendSync(3);
      for (int i = 0; i < int'(VECS[v].n); i++) sendByte(VECS[v].data[8*i +: 8]);
      sendEop();
      jitMode = 0;
      check(doneCnt - bd == 1, $sformatf("R5 vec%0d done count", v), doneCnt - bd, 1);
      check(lastLen == int'(VECS[v].n), $sformatf("R5 vec%0d length", v),
            lastLen, int'(VECS[v].n));
      check(errCnt - be == 0, $sformatf("%s vec%0d no error", tg, v), errCnt - be, 0);
      check(wrCnt - bw == int'(VECS[v].n), $sformatf("R3 vec%0d write count", v),
            wrCnt - bw, int'(VECS[v].n));
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        check(wrLog[bw+i] == VECS[v].data[8*i +: 8],
              $sformatf("%s vec%0d byte%0d", tg, v, i),
              int'(wrLog[bw+i]), int'(VECS[v].data[8*i +: 8]));
        check(wrAddrLog[bw+i] == i, $sformatf("R3 vec%0d addr%0d", v, i),
              wrAddrLog[bw+i], i);
      end
    end

    // R2: longer sync field
    snap();
    sendIdle(3);
    sendSync(5);
    sendByte(8'h3C);
    sendEop();
    check(wrCnt - bw == 1 && wrLog[bw] == 8'h3C, "R2 long sync byte", int'(wrLog[bw]), 8'h3C);
    check(doneCnt - bd == 1, "R2 long sync done", doneCnt - bd, 1);

    // R5: SE0 mid-byte drops the partial byte
    snap();
    sendIdle(3);
    sendSync(3);
    sendByte(8'h96);
    dataBit(1'b1);
    dataBit(1'b0);
    dataBit(1'b1);
    sendEop();
    check(lastLen == 1 && doneCnt - bd == 1, "R5 partial byte length", lastLen, 1);
    check(wrCnt - bw == 1, "R5 partial byte not written", wrCnt - bw, 1);

    // R6: one-bit SE0 in slot 0 fills the slot as 0, packet continues
    snap();
    sendIdle(3);
    sendSync(3);
    sendByte(8'h11);
    se0Bit();
    for (int i = 1; i < 8; i++) dataBit(8'h5A >> i);
    check(doneCnt - bd == 0, "R6 slot0 SE0 did not end packet", doneCnt - bd, 0);
    sendEop();
    check(lastLen == 2, "R6 dribble length", lastLen, 2);
    check(wrLog[bw+1] == 8'h5A, "R6 dribble byte", int'(wrLog[bw+1]), 8'h5A);

    // R7: one byte past the budget
    snap();
    sendIdle(3);
    sendSync(3);
    for (int i = 0; i <= DEPTH; i++) sendByte(8'(i * 17 + 3));
    sendEop();
    check(errCnt - be == 1, "R7 overflow error", errCnt - be, 1);
    check(doneCnt - bd == 0, "R7 overflow no done", doneCnt - bd, 0);
    check(wrCnt - bw == DEPTH, "R7 overflow write count", wrCnt - bw, DEPTH);
    check(wrAddrLog[bw+DEPTH-1] == DEPTH - 1, "R7 last address",
          wrAddrLog[bw+DEPTH-1], DEPTH - 1);
    quickPkt(8'hC9, "R7");

    // R8: K edge followed by a long J
    snap();
    sendIdle(3);
    lvlBit(1'b0);
    sendIdle(4);
    check(errCnt - be == 1, "R8 timeout error", errCnt - be, 1);
    check(doneCnt - bd == 0 && wrCnt - bw == 0, "R8 timeout nothing stored",
          doneCnt - bd + wrCnt - bw, 0);
    quickPkt(8'h42, "R8");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule